// File: doc/BRIEF.md
# Competitive Leaky Integrate-and-Fire Output Layer

This block is the output stage of a spiking classifier. It holds one membrane state per output neuron. On every time-step strobe each state decays by a fixed fraction and takes in that neuron's summed synaptic current. A neuron whose new state rises above its own threshold becomes a candidate to fire. Only the candidate with the largest excess over its threshold fires. On a firing step every neuron's state is wiped, the winner's included.

Each neuron's threshold follows its own firing history. The block counts how many of the most recent examples each neuron fired in. An example ends with a strobe. After a warm-up number of examples, every few example ends, it moves each threshold up or down in proportion to how far that count is from a target. A freeze input holds all thresholds once training is over. The currents arrive already summed and already scaled by the number of inputs. With the default fixed point, 12 fraction bits, the starting threshold of 328 means about 0.08. The default decay factor of 63898/65536 matches a 200 ms time constant at a 5 ms step.

Top module: `wta_lif_layer`

## Requirements
- R1: After reset, `spike_o` and `winner_o` are zero, every membrane state is zero and every threshold is `THR_INIT` (state units).
- R2: On a cycle with `step_i` high, each state becomes sat(trunc0(v·DECAY_Q/2^16) + cur). trunc0 truncates toward zero. sat clamps to the signed `V_W`-bit range. Slice i of `cur_i` is bits [i·CUR_W +: CUR_W], two's complement.
- R3: A neuron is a candidate only when its new state is strictly greater than its threshold. The threshold used is the stored value shifted right by `THR_XB` bits.
- R4: At most one neuron fires per step: the candidate with the largest (state − threshold). Equal margins go to the lowest index. `spike_o` is one-hot with bit i for neuron i. `winner_o` is its index, or 0 on a step with no spike.
- R5: `spike_o` is set only in the cycle after a step. It is zero in every other cycle. `winner_o` holds between steps.
- R6: After a firing step every state is zero, the winner's included. After a step with no spike each state keeps its new value.
- R7: A neuron's activity is the number of the last `WINDOW` examples in which it fired at least once. A spike registered in the same cycle as `ex_end_i` belongs to the next example.
- R8: Thresholds never change during the first `WARMUP` example ends. After that they are updated at every `PERIOD`-th example end, the first at end number `WARMUP+PERIOD`.
- R9: An update adds (activity − WINDOW/TARGET_DIV)·ETA_NUM to the stored threshold, with activity including the example just ended. The stored threshold has `THR_XB` extra fraction bits. The result is clamped to [0, 2^(V_W+THR_XB−1)−1].
- R10: While `freeze_i` is high at an example end, no threshold changes. Activity counting and the update schedule still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Time-step strobe |
| cur_i | input | N_NEUR·CUR_W | Per-neuron summed input currents, signed |
| ex_end_i | input | 1 | End-of-example strobe |
| freeze_i | input | 1 | Hold thresholds at example ends |
| spike_o | output | N_NEUR | One-hot spike vector of the last step |
| winner_o | output | IDX_W | Index of the last winner, 0 when no spike |

## Verification
The hardest situation to reach is a threshold update whose effect shows at the ports. Thresholds are never visible, so the effect appears only when a later step's winner differs from what fixed thresholds would give. The bench shortens the warm-up and window, enlarges the learning rate and biases one neuron's currents so activity becomes uneven. A bench model carries thresholds, windows and states forward and predicts every spike. Directed steps first drive a state into negative saturation, onto the exact threshold and into a margin tie.

// File: rtl/wta_pkg.sv
package wta_pkg;
   // fraction bits of the leak factor
   localparam int DEC_W = 16;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/wta_neuron.sv
module wta_neuron #(
   parameter int V_W     = 16,
   parameter int CUR_W   = 16,
   parameter int DECAY_Q = 63898
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_i,
   input  logic                 clear_i,
   input  logic signed [CUR_W-1:0] cur_i,
   input  logic signed [V_W-1:0]   thr_i,
   output logic signed [V_W-1:0]   v_q,
   output logic signed [V_W:0]     margin_o,
   output logic                 cand_o
);
   import wta_pkg::*;
   localparam int P_W = V_W + DEC_W + 1;
   localparam int S_W = V_W + 2;
   localparam logic signed [P_W-1:0] TRUNC_ADJ = P_W'((64'd1 << DEC_W) - 1);
   localparam logic signed [DEC_W:0] DEC_S     = (DEC_W+1)'(DECAY_Q);
   localparam logic signed [S_W-1:0] V_HI      = S_W'((64'd1 << (V_W-1)) - 1);
   localparam logic signed [S_W-1:0] V_LO      = -V_HI - S_W'(1);

   logic signed [P_W-1:0] prod, prod_t, shifted;
   logic signed [S_W-1:0] sum;
   logic signed [V_W-1:0] v_next;

   always_comb begin
      prod    = P_W'(v_q) * P_W'(DEC_S);
      prod_t  = prod[P_W-1] ? (prod + TRUNC_ADJ) : prod;
      shifted = prod_t >>> DEC_W;
      sum     = S_W'($signed(shifted[V_W-1:0])) + S_W'(cur_i);
      if (sum > V_HI)      v_next = V_HI[V_W-1:0];
      else if (sum < V_LO) v_next = V_LO[V_W-1:0];
      else                 v_next = sum[V_W-1:0];
      margin_o = (V_W+1)'(v_next) - (V_W+1)'(thr_i);
      cand_o   = (margin_o > 0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      v_q <= '0;
      else if (step_i) v_q <= clear_i ? '0 : v_next;
   end
endmodule

// File: rtl/wta_pick.sv
module wta_pick #(
   parameter int N     = 8,
   parameter int M_W   = 17,
   parameter int IDX_W = 3
) (
   input  logic [N*M_W-1:0] margin_i,
   input  logic [N-1:0]     cand_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o
);
   logic signed [M_W-1:0] best;
   logic signed [M_W-1:0] m;

   // scan upward; strict compare keeps the lowest index on a tie
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      best  = '0;
      m     = '0;
      for (int i = 0; i < N; i++) begin
         m = $signed(margin_i[i*M_W +: M_W]);
         if (cand_i[i] && (!hit_o || m > best)) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
            best  = m;
         end
      end
   end
endmodule

// File: rtl/wta_homeo.sv
module wta_homeo #(
   parameter int WINDOW  = 100,
   parameter int CNT_W   = 7,
   parameter int THR_W   = 24,
   parameter int THR_RST = 83968,
   parameter int TARGET  = 2,
   parameter int ETA_NUM = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ex_end_i,
   input  logic             adapt_i,
   input  logic             fired_i,
   output logic [THR_W-1:0] thr_q
);
   localparam int D_W = THR_W + 2;
   localparam logic signed [D_W-1:0] THR_MAX = D_W'((64'd1 << (THR_W-1)) - 1);

   logic [WINDOW-1:0]     hist_q;
   logic [CNT_W-1:0]      cnt_q, cnt_new;
   logic signed [D_W-1:0] delta, thr_sum;
   logic [THR_W-1:0]      thr_next;

   always_comb begin
      cnt_new = cnt_q + CNT_W'(fired_i) - CNT_W'(hist_q[WINDOW-1]);
      delta   = ($signed(D_W'(cnt_new)) - D_W'(TARGET)) * D_W'(ETA_NUM);
      thr_sum = $signed(D_W'(thr_q)) + delta;
      if (thr_sum < 0)            thr_next = '0;
      else if (thr_sum > THR_MAX) thr_next = THR_MAX[THR_W-1:0];
      else                        thr_next = thr_sum[THR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
         cnt_q  <= '0;
         thr_q  <= THR_W'(THR_RST);
      end else if (ex_end_i) begin
         hist_q <= {hist_q[WINDOW-2:0], fired_i};
         cnt_q  <= cnt_new;
         if (adapt_i) thr_q <= thr_next;
      end
   end
endmodule

// File: rtl/wta_lif_layer.sv
module wta_lif_layer #(
   parameter int N_NEUR     = 8,
   parameter int V_W        = 16,
   parameter int CUR_W      = 16,
   parameter int THR_XB     = 8,
   parameter int THR_INIT   = 328,
   parameter int DECAY_Q    = 63898,
   parameter int WINDOW     = 100,
   parameter int TARGET_DIV = 50,
   parameter int WARMUP     = 1000,
   parameter int PERIOD     = 2,
   parameter int ETA_NUM    = 5,
   localparam int IDX_W     = wta_pkg::idx_width(N_NEUR)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      step_i,
   input  logic [N_NEUR*CUR_W-1:0]   cur_i,
   input  logic                      ex_end_i,
   input  logic                      freeze_i,
   output logic [N_NEUR-1:0]         spike_o,
   output logic [IDX_W-1:0]          winner_o
);
   localparam int THR_W  = V_W + THR_XB;
   localparam int M_W    = V_W + 1;
   localparam int CNT_W  = $clog2(WINDOW + 1);
   localparam int TARGET = WINDOW / TARGET_DIV;
   localparam int WRM_W  = $clog2(WARMUP + 2);
   localparam int PH_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   // elaboration-time parameter checks
   if (N_NEUR < 2)                   $error("N_NEUR must be at least 2");
   if (CUR_W > V_W)                  $error("CUR_W must not exceed V_W");
   if (WINDOW < 2)                   $error("WINDOW must be at least 2");
   if (TARGET_DIV < 1 || TARGET_DIV > WINDOW) $error("TARGET_DIV out of range");
   if (PERIOD < 1)                   $error("PERIOD must be at least 1");
   if (DECAY_Q < 0 || DECAY_Q >= (1 << wta_pkg::DEC_W)) $error("DECAY_Q out of range");
   if (THR_INIT < 0 || THR_INIT >= (1 << (V_W-1)))      $error("THR_INIT out of range");
   if (longint'(ETA_NUM) * WINDOW >= (64'd1 << (THR_W-2))) $error("ETA_NUM too large");

   logic [N_NEUR*V_W-1:0]   v_flat;
   logic [N_NEUR*THR_W-1:0] thr_flat;
   logic [N_NEUR*M_W-1:0]   margin_flat;
   logic [N_NEUR-1:0]       cand, fired_q, spike_now;
   logic                    hit;
   logic [IDX_W-1:0]        idx;
   logic [WRM_W-1:0]        warm_q;
   logic [PH_W-1:0]         phase_q;
   logic                    warm_done, adapt;

   for (genvar g = 0; g < N_NEUR; g++) begin : g_neur
      logic signed [V_W-1:0] v_g;
      logic signed [M_W-1:0] m_g;
      logic [THR_W-1:0]      thr_g;

      wta_neuron #(.V_W(V_W), .CUR_W(CUR_W), .DECAY_Q(DECAY_Q)) u_neur (
         .clk(clk), .rst_n(rst_n), .step_i(step_i), .clear_i(hit),
         .cur_i($signed(cur_i[g*CUR_W +: CUR_W])),
         .thr_i($signed(thr_g[THR_W-1:THR_XB])),
         .v_q(v_g), .margin_o(m_g), .cand_o(cand[g]));

      wta_homeo #(.WINDOW(WINDOW), .CNT_W(CNT_W), .THR_W(THR_W),
                  .THR_RST(THR_INIT << THR_XB), .TARGET(TARGET),
                  .ETA_NUM(ETA_NUM)) u_homeo (
         .clk(clk), .rst_n(rst_n), .ex_end_i(ex_end_i), .adapt_i(adapt),
         .fired_i(fired_q[g]), .thr_q(thr_g));

      assign v_flat[g*V_W +: V_W]       = v_g;
      assign margin_flat[g*M_W +: M_W]  = m_g;
      assign thr_flat[g*THR_W +: THR_W] = thr_g;
   end

   wta_pick #(.N(N_NEUR), .M_W(M_W), .IDX_W(IDX_W)) u_pick (
      .margin_i(margin_flat), .cand_i(cand), .hit_o(hit), .idx_o(idx));

   assign spike_now = (step_i && hit) ? (N_NEUR'(1) << idx) : '0;
   assign warm_done = (warm_q == WRM_W'(WARMUP));
   assign adapt     = ex_end_i && warm_done && !freeze_i &&
                      (phase_q == PH_W'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         warm_q   <= '0;
         phase_q  <= '0;
         fired_q  <= '0;
         spike_o  <= '0;
         winner_o <= '0;
      end else begin
         spike_o <= spike_now;
         if (step_i) winner_o <= hit ? idx : '0;
         if (ex_end_i) begin
            fired_q <= spike_now;
            if (!warm_done)                         warm_q  <= warm_q + 1'b1;
            else if (phase_q == PH_W'(PERIOD - 1))  phase_q <= '0;
            else                                    phase_q <= phase_q + 1'b1;
         end else begin
            fired_q <= fired_q | spike_now;
         end
      end
   end
endmodule

// File: rtl/wta_lif_layer_chk.sv
module wta_lif_layer_chk #(
   parameter int N     = 8,
   parameter int V_W   = 16,
   parameter int THR_W = 24,
   parameter int IDX_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               step_i,
   input logic               ex_end_i,
   input logic               freeze_i,
   input logic [N-1:0]       spike_o,
   input logic [IDX_W-1:0]   winner_o,
   input logic [N*V_W-1:0]   v_flat,
   input logic [N*THR_W-1:0] thr_flat
);
   assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(spike_o));

   assert_winner_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (spike_o != '0) |-> spike_o[winner_o]);

   assert_spike_after_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (spike_o != '0) |-> $past(step_i));

   assert_all_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (spike_o != '0) |-> (v_flat == '0));

   assert_thr_only_at_ex_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_end_i |=> $stable(thr_flat));

   assert_thr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_i |=> $stable(thr_flat));
endmodule

bind wta_lif_layer wta_lif_layer_chk #(
   .N(N_NEUR), .V_W(V_W), .THR_W(THR_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step_i(step_i), .ex_end_i(ex_end_i),
   .freeze_i(freeze_i), .spike_o(spike_o), .winner_o(winner_o),
   .v_flat(v_flat), .thr_flat(thr_flat)
);

// File: tb/wta_lif_layer_test.sv
`timescale 1ns/1ps
module wta_lif_layer_test;
   localparam int TN = 4, TVW = 16, TCW = 14, TXB = 8, TINIT = 328;
   localparam int TDEC = 63898, TWIN = 10, TDIV = 5, TWARM = 4, TPER = 2;
   localparam int TETA = 4096;
   localparam int TIW = 2;
   localparam longint THR_MAXV = (64'd1 << (TVW + TXB - 1)) - 1;

   logic clk = 1'b0, rst_n = 1'b0, step_i = 1'b0, ex_end_i = 1'b0, freeze_i = 1'b0;
   logic [TN*TCW-1:0] cur_i = '0;
   logic [TN-1:0]     spike_o;
   logic [TIW-1:0]    winner_o;

   int total = 0, bad = 0;
   bit done = 0;

   // bench model state
   int     v_m[TN];
   longint thr_m[TN];
   bit     hist_m[TN][TWIN];
   int     cnt_m[TN];
   bit     fired_m[TN];
   int     warm_m = 0, phase_m = 0;

   always #2.5 clk = ~clk;

   wta_lif_layer #(.N_NEUR(TN), .V_W(TVW), .CUR_W(TCW), .THR_XB(TXB),
      .THR_INIT(TINIT), .DECAY_Q(TDEC), .WINDOW(TWIN), .TARGET_DIV(TDIV),
      .WARMUP(TWARM), .PERIOD(TPER), .ETA_NUM(TETA)) uut (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .cur_i(cur_i),
      .ex_end_i(ex_end_i), .freeze_i(freeze_i),
      .spike_o(spike_o), .winner_o(winner_o));

   function automatic int decay(input int v);
      longint p = longint'(v) * TDEC;
      return (p < 0) ? -int'((-p) >>> 16) : int'(p >>> 16);
   endfunction

   function automatic int sat(input int x);
      if (x > 32767)  return 32767;
      if (x < -32768) return -32768;
      return x;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_step(input int c[TN], input string tag);
      int vn[TN];
      int best = 0, widx = 0, m;
      bit hit = 0;
      for (int i = 0; i < TN; i++) begin
         cur_i[i*TCW +: TCW] = TCW'(c[i]);
         vn[i] = sat(decay(v_m[i]) + c[i]);
      end
      for (int i = 0; i < TN; i++) begin
         m = vn[i] - int'(thr_m[i] >>> TXB);
         if (m > 0 && (!hit || m > best)) begin hit = 1; best = m; widx = i; end
      end
      for (int i = 0; i < TN; i++) v_m[i] = hit ? 0 : vn[i];
      if (hit) fired_m[widx] = 1;
      step_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      step_i = 1'b0;
      check({tag, " spike"}, spike_o, hit ? (longint'(1) << widx) : 0);
      check({tag, " winner"}, winner_o, hit ? widx : 0);
      @(negedge clk);
      check("R5 pulse", spike_o, 0);
      check("R5 hold", winner_o, hit ? widx : 0);
   endtask

   task automatic do_ex_end(input bit frz);
      bit adapt = (warm_m >= TWARM) && (phase_m == TPER - 1) && !frz;
      for (int i = 0; i < TN; i++) begin
         cnt_m[i] = cnt_m[i] + int'(fired_m[i]) - int'(hist_m[i][TWIN-1]);
         for (int k = TWIN - 1; k > 0; k--) hist_m[i][k] = hist_m[i][k-1];
         hist_m[i][0] = fired_m[i];
         fired_m[i] = 0;
         if (adapt) begin
            thr_m[i] = thr_m[i] + longint'(cnt_m[i] - TWIN / TDIV) * TETA;
            if (thr_m[i] < 0) thr_m[i] = 0;
            if (thr_m[i] > THR_MAXV) thr_m[i] = THR_MAXV;
         end
      end
      if (warm_m < TWARM) warm_m++;
      else phase_m = (phase_m == TPER - 1) ? 0 : phase_m + 1;
      freeze_i = frz;
      ex_end_i = 1'b1;
      @(negedge clk);
      ex_end_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20231));
      for (int i = 0; i < TN; i++) begin
         v_m[i] = 0; thr_m[i] = longint'(TINIT) << TXB; cnt_m[i] = 0; fired_m[i] = 0;
         for (int k = 0; k < TWIN; k++) hist_m[i][k] = 0;
      end
      repeat (4) @(negedge clk);
      check("R1 spike", spike_o, 0);
      check("R1 winner", winner_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // state lands exactly on the initial threshold: no spike (R1, R3)
      do_step('{TINIT, 0, 0, 0}, "R1 R3 equal");
      // one count above after leak: spike (R2, R3)
      do_step('{10, 0, 0, 0}, "R2 R3 above");
      // equal margins on 1 and 2: lowest index wins
      do_step('{400, 500, 500, 0}, "R4 tie");
      // all states cleared, so zero input gives no spike
      do_step('{0, 0, 0, 0}, "R6 cleared");
      // negative state decays toward zero with truncation
      do_step('{-1000, -1000, 0, 0}, "R2 negative");
      do_step('{0, 0, 0, 0}, "R2 negative leak");
      do_step('{1302, 0, 0, 0}, "R2 trunc");
      // drive neuron 3 into negative saturation, then climb back
      for (int s = 0; s < 6; s++) do_step('{0, 0, 0, -8191}, "R2 sat low");
      for (int s = 0; s < 6; s++) do_step('{0, 0, 0, 8191}, "R2 sat climb");
      // no-spike steps keep integrating (R6)
      do_step('{100, 90, 80, 70}, "R6 keep");
      do_step('{100, 90, 80, 70}, "R6 keep");

      // random examples: warm-up, adaptation, then frozen thresholds
      for (int ex = 0; ex < 70; ex++) begin
         bit frz = (ex >= 50);
         string tag = (ex < TWARM) ? "R2 R8 warmup" : (frz ? "R10 frozen" : "R7 R8 R9 adapt");
         for (int s = 0; s < 4; s++) begin
            int c[TN];
            for (int i = 0; i < TN; i++)
               c[i] = int'($urandom_range(0, 260)) - 40 + ((i == 2) ? 140 : 0);
            do_step(c, tag);
         end
         do_ex_end(frz);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule